// File: doc/BRIEF.md
# Wear-Leveled Flash Page Array

This block is a synthesizable behavioural model of a small flash memory: a few erase blocks, each split into pages of one data word. One command port carries three operations (read one page, program one page, erase one block). The model keeps the physical rules of flash cells. A program can only pull bits from one to zero, so the stored word becomes the old word ANDed with the new data. The only way back to ones is to erase the whole block that holds the page.

Every block has its own erase counter. Once a counter reaches a configurable limit, that block is worn out and cannot be erased again. A wear-leveling allocator looks at all blocks. It reports the block that is neither worn out nor programmed since its last erase and that has the lowest erase count. A controller uses this as the next write target. Busy, error and read-data outputs complete the interface.

Top module: `flash_wl_array`

## Requirements
- R1: After reset every bit of every page reads as one, `busy` and `err` are low, and the allocator reports block 0 with `alloc_valid` high.
- R2: A read (`cmd_op` = 2'b00) accepted on a clock edge raises `rd_valid` for exactly the next cycle, with `rd_data` holding the addressed page. It does not raise `busy`. `cmd_addr` is {block, page}, with the block in the upper bits.
- R3: A program (`cmd_op` = 2'b01) leaves the addressed page holding the bitwise AND of its previous content and `cmd_wdata`.
- R4: If a program's data has a one where the stored word has a zero, `err` is high for the single cycle after acceptance, and the AND result is still stored.
- R5: An erase (`cmd_op` = 2'b10) sets every page of the addressed block to all ones and leaves other blocks unchanged.
- R6: After an accepted program, `busy` is high for PROG_CYCLES cycles. After an accepted erase, `busy` is high for ERASE_CYCLES cycles.
- R7: A command presented while `busy` is high is rejected. `err` is high in the next cycle, and the command changes no page and gives no read response.
- R8: Each accepted erase adds one to the block's counter. A block whose counter equals ERASE_LIMIT is worn out. An erase addressed to it is refused: `err` is high in the next cycle, no page changes, and `busy` stays low.
- R9: The allocator names the block with the fewest erases among blocks that are not worn out and have not been programmed since their last erase or reset. Ties go to the lowest block index. `alloc_valid` is low when no block qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 program, 10 erase, 11 no operation |
| cmd_addr | input | BLK_W+PAGE_W | {block, page} target |
| cmd_wdata | input | WORD_W | Program data |
| rd_data | output | WORD_W | Page content returned by a read |
| rd_valid | output | 1 | rd_data is valid this cycle |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | One-cycle error pulse |
| alloc_valid | output | 1 | A qualifying block exists |
| alloc_block | output | BLK_W | Suggested next write block |

## Verification
The hardest states to reach are a worn-out block and allocator ties. Both need long erase histories, and the busy window after each erase must be respected while building them. The stimulus programs blocks to remove them from the candidate set, then erases selected blocks repeatedly. This produces an equal-count tie, then a strict minimum, then a block at the limit. A final erase of the worn block is refused, and a read shows that its programmed content survived. Another program then empties the candidate set.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_NONE  = 2'b11
    } flash_op_e;

    typedef struct packed {
        logic do_read;
        logic do_prog;
        logic do_erase;
        logic reject;
    } flash_act_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_page_store.sv
module flash_page_store #(
    parameter int NUM_BLOCKS      = 4,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int WORD_W          = 16,
    parameter int BLK_W           = 2,
    parameter int PAGE_W          = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  blk,
    input  logic [PAGE_W-1:0] page,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cur_word
);
    localparam int DEPTH = NUM_BLOCKS * PAGES_PER_BLOCK;

    logic [WORD_W-1:0] cells [DEPTH];
    int                sel;

    assign sel      = int'(blk) * PAGES_PER_BLOCK + int'(page);
    assign cur_word = cells[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (prog_en) begin
            cells[sel] <= cells[sel] & wdata;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (BLK_W'(i / PAGES_PER_BLOCK) == blk) cells[i] <= '1;
        end
    end
endmodule

// File: rtl/flash_wear_tracker.sv
module flash_wear_tracker #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLK_W       = 2,
    parameter int CNT_W       = 2,
    parameter int ERASE_LIMIT = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [BLK_W-1:0]                 blk,
    input  logic                             prog_en,
    input  logic                             erase_en,
    output logic [NUM_BLOCKS-1:0][CNT_W-1:0] cnt,
    output logic [NUM_BLOCKS-1:0]            worn,
    output logic [NUM_BLOCKS-1:0]            fresh
);
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic hit;
        assign hit     = (blk == BLK_W'(b));
        assign worn[b] = (cnt[b] == CNT_W'(ERASE_LIMIT));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[b]   <= '0;
                fresh[b] <= 1'b1;
            end else if (erase_en && hit) begin
                cnt[b]   <= cnt[b] + 1'b1;
                fresh[b] <= 1'b1;
            end else if (prog_en && hit) begin
                fresh[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_wear_alloc.sv
module flash_wear_alloc #(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_W      = 2,
    parameter int CNT_W      = 2
) (
    input  logic [NUM_BLOCKS-1:0][CNT_W-1:0] cnt,
    input  logic [NUM_BLOCKS-1:0]            worn,
    input  logic [NUM_BLOCKS-1:0]            fresh,
    output logic                             found,
    output logic [BLK_W-1:0]                 pick
);
    logic [CNT_W-1:0] best;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (fresh[b] && !worn[b] && (!found || cnt[b] < best)) begin
                found = 1'b1;
                pick  = BLK_W'(b);
                best  = cnt[b];
            end
        end
    end
endmodule

// File: rtl/flash_wl_array.sv
module flash_wl_array
    import flash_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int WORD_W          = 16,
    parameter int ERASE_LIMIT     = 3,
    parameter int PROG_CYCLES     = 2,
    parameter int ERASE_CYCLES    = 6,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK),
    localparam int ADDR_W         = BLK_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              err,
    output logic              alloc_valid,
    output logic [BLK_W-1:0]  alloc_block
);
    localparam int CNT_W  = $clog2(ERASE_LIMIT + 1);
    localparam int BUSY_W = $clog2(max_int(PROG_CYCLES, ERASE_CYCLES) + 1);

    logic [BLK_W-1:0]                 cmd_blk;
    logic [PAGE_W-1:0]                cmd_page;
    logic [WORD_W-1:0]                cur_word;
    logic [NUM_BLOCKS-1:0][CNT_W-1:0] blk_cnt;
    logic [NUM_BLOCKS-1:0]            blk_worn;
    logic [NUM_BLOCKS-1:0]            blk_fresh;
    logic [BUSY_W-1:0]                busy_left;
    flash_op_e                        op;
    flash_act_t                       act;
    logic                             lifts_bit;

    assign cmd_blk  = cmd_addr[ADDR_W-1:PAGE_W];
    assign cmd_page = cmd_addr[PAGE_W-1:0];
    assign op       = flash_op_e'(cmd_op);
    assign busy     = (busy_left != '0);

    always_comb begin
        act = '0;
        if (cmd_valid) begin
            if (busy) act.reject = 1'b1;
            else begin
                unique case (op)
                    OP_READ:  act.do_read = 1'b1;
                    OP_PROG:  act.do_prog = 1'b1;
                    OP_ERASE: begin
                        if (blk_worn[cmd_blk]) act.reject   = 1'b1;
                        else                   act.do_erase = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign lifts_bit = act.do_prog && (|(~cur_word & cmd_wdata));

    flash_page_store #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .WORD_W(WORD_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W)
    ) u_store (
        .clk(clk), .rst(rst), .blk(cmd_blk), .page(cmd_page),
        .prog_en(act.do_prog), .erase_en(act.do_erase),
        .wdata(cmd_wdata), .cur_word(cur_word)
    );

    flash_wear_tracker #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .CNT_W(CNT_W),
        .ERASE_LIMIT(ERASE_LIMIT)
    ) u_wear (
        .clk(clk), .rst(rst), .blk(cmd_blk),
        .prog_en(act.do_prog), .erase_en(act.do_erase),
        .cnt(blk_cnt), .worn(blk_worn), .fresh(blk_fresh)
    );

    flash_wear_alloc #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .CNT_W(CNT_W)
    ) u_alloc (
        .cnt(blk_cnt), .worn(blk_worn), .fresh(blk_fresh),
        .found(alloc_valid), .pick(alloc_block)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_left <= '0;
            err       <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (act.do_prog)       busy_left <= BUSY_W'(PROG_CYCLES);
            else if (act.do_erase) busy_left <= BUSY_W'(ERASE_CYCLES);
            else if (busy)         busy_left <= busy_left - 1'b1;
            err      <= act.reject | lifts_bit;
            rd_valid <= act.do_read;
            if (act.do_read) rd_data <= cur_word;
        end
    end
endmodule

// File: rtl/flash_wl_array_chk.sv
module flash_wl_array_chk #(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_W      = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic [1:0]            cmd_op,
    input logic [BLK_W-1:0]      cmd_blk,
    input logic                  busy,
    input logic                  err,
    input logic                  rd_valid,
    input logic                  alloc_valid,
    input logic [BLK_W-1:0]      alloc_block,
    input logic [NUM_BLOCKS-1:0] wear_worn,
    input logic [NUM_BLOCKS-1:0] wear_fresh
);
    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && cmd_op == 2'b00 |=> rd_valid);

    // R7
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && busy |=> err && !rd_valid);

    // R6
    prog_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && cmd_op == 2'b01 |=> busy);

    // R8
    worn_erase_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && cmd_op == 2'b10 && wear_worn[cmd_blk] |=> err && !busy);

    // R9
    alloc_pick_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> wear_fresh[alloc_block] && !wear_worn[alloc_block]);
endmodule

bind flash_wl_array flash_wl_array_chk #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_addr[ADDR_W-1:PAGE_W]), .busy(busy), .err(err),
    .rd_valid(rd_valid), .alloc_valid(alloc_valid), .alloc_block(alloc_block),
    .wear_worn(blk_worn), .wear_fresh(blk_fresh)
);

// File: tb/flash_wl_array_test.sv
module flash_wl_array_test;
    localparam int PROG_CYCLES  = 2;
    localparam int ERASE_CYCLES = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b11;
    logic [3:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid, busy, err, alloc_valid;
    logic [1:0]  alloc_block;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    flash_wl_array #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .err(err),
        .alloc_valid(alloc_valid), .alloc_block(alloc_block)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read word whenever a read response appears (R2)
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) check(0, "R2 unexpected read response", rd_data, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R2 read data", rd_data, e);
            end
        end
    end

    // Driver: called at a negedge; returns at the following negedge with err sampled
    task automatic send(input logic [1:0] op, input logic [3:0] addr,
                        input logic [15:0] data, input bit wait_idle, output logic e);
        if (wait_idle) while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        e = err;
    endtask

    task automatic rd(input logic [3:0] addr, input logic [15:0] exp);
        logic e;
        exp_q.push_back(exp);
        send(2'b00, addr, '0, 1, e);
    endtask

    task automatic prog(input logic [3:0] addr, input logic [15:0] data,
                        input logic exp_err, input string tag);
        logic e;
        send(2'b01, addr, data, 1, e);
        check(e == exp_err, tag, e, exp_err);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic check_alloc(input logic v, input logic [1:0] b, input string tag);
        while (busy) @(negedge clk);
        check(alloc_valid == v, tag, alloc_valid, v);
        if (v) check(alloc_block == b, tag, alloc_block, b);
    endtask

    initial begin
        logic e;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(err == 0, "R1 err after reset", err, 0);
        check_alloc(1, 0, "R1 alloc after reset");
        for (int i = 0; i < 16; i++) rd(4'(i), 16'hFFFF);
        check(busy == 0, "R6 read leaves busy low", busy, 0);

        // R3 program, R6 program busy window
        send(2'b01, 4'h1, 16'hA5A5, 1, e);
        check(e == 0, "R3 clean program no err", e, 0);
        count_busy(n);
        check(n == PROG_CYCLES, "R6 program busy cycles", n, PROG_CYCLES);
        rd(4'h1, 16'hA5A5);
        check_alloc(1, 1, "R9 programmed block leaves candidates");

        // R4 lifting a zero bit flags error, AND still stored
        prog(4'h1, 16'h0F0F, 1, "R4 lift flagged");
        rd(4'h1, 16'h0505);
        prog(4'h1, 16'h0404, 0, "R3 subset program no err");
        rd(4'h1, 16'h0404);

        // R7 command while busy rejected
        send(2'b01, 4'h2, 16'h00FF, 1, e);
        send(2'b01, 4'h3, 16'h0000, 0, e);
        check(e == 1, "R7 busy reject err", e, 1);
        rd(4'h3, 16'hFFFF);
        rd(4'h2, 16'h00FF);

        // R5 erase of block 0 leaves block 1 alone
        prog(4'h4, 16'h1234, 0, "R3 program block1");
        send(2'b10, 4'h0, '0, 1, e);
        check(e == 0, "R5 erase accepted", e, 0);
        count_busy(n);
        check(n == ERASE_CYCLES, "R6 erase busy cycles", n, ERASE_CYCLES);
        rd(4'h1, 16'hFFFF);
        rd(4'h2, 16'hFFFF);
        rd(4'h4, 16'h1234);
        check_alloc(1, 2, "R9 fewest erases chosen");

        // R9 tie handling and minimum
        prog(4'h8, 16'h0000, 0, "R3 program block2");
        prog(4'hC, 16'h0000, 0, "R3 program block3");
        check_alloc(1, 0, "R9 only block0 fresh");
        send(2'b10, 4'h4, '0, 1, e);
        check_alloc(1, 0, "R9 tie to lowest index");
        send(2'b10, 4'h0, '0, 1, e);
        check_alloc(1, 1, "R9 strict minimum");

        // R8 third erase wears block 0 out
        send(2'b10, 4'h0, '0, 1, e);
        check_alloc(1, 1, "R8 worn block excluded");
        prog(4'h0, 16'h0000, 0, "R3 program worn block");
        while (busy) @(negedge clk);
        send(2'b10, 4'h0, '0, 1, e);
        check(e == 1, "R8 worn erase refused err", e, 1);
        check(busy == 0, "R8 refused erase no busy", busy, 0);
        rd(4'h0, 16'h0000);
        prog(4'h5, 16'hFFFF, 0, "R3 program block1 again");
        check_alloc(0, 0, "R9 no candidate");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule